// File: doc/BRIEF.md
# SD Bus Supply Control Register

This block is the 8-bit control register that governs the two card supplies of an SD host: the main card supply (VDD1) and the secondary supply used by UHS-II signalling (VDD2). Software loads the register through a synchronous byte write port and reads it back at any time. Each supply has an enable bit and a 3-bit voltage code.

A supply enable only reaches the regulator when the selected voltage code is one that the host's capability inputs report as supported. The card-present input is synchronised and clears the VDD1 enable bit in hardware when the card goes away. A small sequencer controls the pads of CMD, DAT[3:0] and SDCLK whenever the VDD1 supply is removed. It first drives the lines low, then removes the supply, and only then tri-states the lines. No line is left driving into an unpowered card.

Top module: `sd_supply_ctrl`

## Requirements
- R1: After reset the register reads 0x00, both supply enables are 0, SDCLK is forced low, and CMD and all DAT lines are tri-stated with no low drive.
- R2: With wr_en high at a clock edge the whole byte is loaded and rd_data shows it from that edge on. Field layout: bit 0 VDD1 enable, bits 3:1 VDD1 code, bit 4 VDD2 enable, bits 7:5 VDD2 code.
- R3: vdd1_en rises one cycle after the register holds VDD1 enable = 1 with a qualified code. Code 101 needs cap_vdd1_18, 110 needs cap_vdd1_30, and 111 needs cap_vdd1_33. Codes 000 to 100 never enable the supply.
- R4: card_present passes through a 2-flop synchroniser. On the third clock edge after it falls, the VDD1 enable bit clears without a write. This clear overrides a software write in the same cycle.
- R5: vdd2_en is 1 exactly when bit 4 is 1, bits 7:5 are 101 and cap_vdd2_18 is 1. It follows the register and the capability input in the same cycle.
- R6: sdclk_low is 1 whenever the VDD1 enable bit reads 0 or vdd1_en is 0.
- R7: With a card present, loss of VDD1 qualification while the supply is on starts a sequence on the next edge. CMD and DAT[3:0] are driven low for DRIVE_LOW_CYCLES (default 8) cycles with vdd1_en still 1. Then vdd1_en drops for one cycle while the lines stay low. Then the lines are tri-stated.
- R8: With no card present, UHS-II mode on and DAT[2] used as out-of-band interrupt, the same sequence runs. Only DAT[2] is driven low; CMD and the other DAT lines are tri-stated.
- R9: With no card present and no out-of-band use of DAT[2], vdd1_en drops on the edge after qualification is lost, and every line is tri-stated at once.
- R10: While the supply is on and no power-down is in progress, no line override is active (all drive-low and tri-state outputs are 0). While fully off, every line is tri-stated.
- R11: vdd1_sel and vdd2_sel always mirror register bits 3:1 and 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to load |
| rd_data | output | 8 | Current register contents |
| card_present | input | 1 | Asynchronous card-detected level |
| cap_vdd1_18 | input | 1 | VDD1 1.8V supported |
| cap_vdd1_30 | input | 1 | VDD1 3.0V supported |
| cap_vdd1_33 | input | 1 | VDD1 3.3V supported |
| cap_vdd2_18 | input | 1 | VDD2 1.8V supported |
| uhs2_mode | input | 1 | Host is in UHS-II mode |
| dat2_oob_irq | input | 1 | DAT[2] carries an out-of-band interrupt |
| vdd1_en | output | 1 | Qualified VDD1 regulator enable |
| vdd1_sel | output | 3 | VDD1 voltage code |
| vdd2_en | output | 1 | Qualified VDD2 regulator enable |
| vdd2_sel | output | 3 | VDD2 voltage code |
| sdclk_low | output | 1 | Force SDCLK to low level |
| cmd_drive_low | output | 1 | Drive CMD low |
| cmd_hiz | output | 1 | Tri-state CMD |
| dat_drive_low | output | 4 | Drive DAT[n] low |
| dat_hiz | output | 4 | Tri-state DAT[n] |

## Verification
The VDD1 qualifier is tried with every code class against matching and missing capability bits. This separates reserved codes, unsupported-but-valid codes and accepted codes. The power-down sequencer runs under three stimulus patterns: a software clear with a card present, card removal in UHS-II mode with DAT[2] used as an interrupt, and plain card removal. The resulting line masks and the cycle at which vdd1_en drops tell the full-sequence, DAT[2]-only and immediate paths apart. A write issued while the card is absent separates hardware-clear priority from write priority. The VDD2 enable is toggled through its power bit, its code and its capability input one at a time.

// File: rtl/sdpwr_pkg.sv
// Package: shared field layout, voltage codes and sequencer states for the
// SD bus supply control register. Assumes the 8-bit layout below is fixed.
package sdpwr_pkg;

    localparam int REG_W  = 8;
    localparam int CODE_W = 3;

    // Voltage codes recognised by the qualifier
    localparam logic [CODE_W-1:0] CODE_1V8 = 3'b101;
    localparam logic [CODE_W-1:0] CODE_3V0 = 3'b110;
    localparam logic [CODE_W-1:0] CODE_3V3 = 3'b111;

    // Register image, MSB first
    typedef struct packed {
        logic [CODE_W-1:0] vdd2_code;
        logic              vdd2_on;
        logic [CODE_W-1:0] vdd1_code;
        logic              vdd1_on;
    } supply_reg_t;

    // Power-down sequencer states
    typedef enum logic [1:0] {
        PS_OFF        = 2'd0,
        PS_ON         = 2'd1,
        PS_DRIVE_LOW  = 2'd2,
        PS_SUPPLY_OFF = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/sdpwr_sync.sv
// Module: multi-flop level synchroniser for the card-present input.
// Assumes STAGES >= 2 and a slowly changing level input.
module sdpwr_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sdpwr_regfile.sv
// Module: the supply control byte. Software loads the whole byte; a hardware
// clear of the VDD1 enable bit overrides a write in the same cycle.
// Assumes hw_clr_vdd1 is already synchronous to clk.
module sdpwr_regfile
    import sdpwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hw_clr_vdd1,
    output supply_reg_t      regs
);

    supply_reg_t regs_nxt;

    // Next register value: write first, then hardware clear on top
    always_comb begin
        regs_nxt = regs;
        if (wr_en) begin
            regs_nxt = supply_reg_t'(wr_data);
        end
        if (hw_clr_vdd1) begin
            regs_nxt.vdd1_on = 1'b0;
        end
    end

    // Register storage with synchronous reset to all zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            regs <= regs_nxt;
        end
    end

endmodule

// File: rtl/sdpwr_qualify.sv
// Module: decides whether each supply request is backed by a supported
// voltage code. Purely combinational; capability inputs are static levels.
module sdpwr_qualify
    import sdpwr_pkg::*;
(
    input  supply_reg_t regs,
    input  logic        cap_vdd1_18,
    input  logic        cap_vdd1_30,
    input  logic        cap_vdd1_33,
    input  logic        cap_vdd2_18,
    output logic        vdd1_ok,
    output logic        vdd2_ok
);

    logic vdd1_code_ok;
    logic vdd2_code_ok;

    // VDD1: each valid code needs its own capability bit
    always_comb begin
        unique case (regs.vdd1_code)
            CODE_1V8: vdd1_code_ok = cap_vdd1_18;
            CODE_3V0: vdd1_code_ok = cap_vdd1_30;
            CODE_3V3: vdd1_code_ok = cap_vdd1_33;
            default:  vdd1_code_ok = 1'b0;
        endcase
    end

    // VDD2: only the 1.8V code is usable, and only when supported
    always_comb begin
        vdd2_code_ok = (regs.vdd2_code == CODE_1V8) && cap_vdd2_18;
    end

    // Combine enable bits with code checks
    always_comb begin
        vdd1_ok = regs.vdd1_on && vdd1_code_ok;
        vdd2_ok = regs.vdd2_on && vdd2_code_ok;
    end

endmodule

// File: rtl/sdpwr_seq.sv
// Module: VDD1 power-up and power-down sequencer with pad overrides.
// On loss of qualification it drives the selected lines low for
// DRIVE_LOW_CYCLES, drops the supply for one cycle, then tri-states.
// Assumes DRIVE_LOW_CYCLES >= 1 and card_ok synchronous to clk.
module sdpwr_seq
    import sdpwr_pkg::*;
#(
    parameter int DRIVE_LOW_CYCLES = 8,
    parameter int DAT_W            = 4,
    parameter int OOB_LINE         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vdd1_ok,
    input  logic             card_ok,
    input  logic             uhs2_mode,
    input  logic             dat2_oob_irq,
    output pwr_state_e       state,
    output logic             vdd1_en,
    output logic             cmd_drive_low,
    output logic             cmd_hiz,
    output logic [DAT_W-1:0] dat_drive_low,
    output logic [DAT_W-1:0] dat_hiz
);

    localparam int CNT_W = $clog2(DRIVE_LOW_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRIVE_LOW_CYCLES - 1);

    pwr_state_e       state_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             cmd_low_q;
    logic [DAT_W-1:0] dat_low_q;
    logic [DAT_W-1:0] oob_mask;
    logic             oob_active;
    logic             need_low;

    // Mask selecting the out-of-band interrupt line, if the bus has it
    generate
        if (DAT_W > OOB_LINE) begin : g_oob
            assign oob_mask = {{(DAT_W-1){1'b0}}, 1'b1} << OOB_LINE;
        end else begin : g_no_oob
            assign oob_mask = '0;
        end
    endgenerate

    assign oob_active = uhs2_mode && dat2_oob_irq;
    assign need_low   = card_ok || oob_active;

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_OFF:        if (vdd1_ok) state_nxt = PS_ON;
            PS_ON:         if (!vdd1_ok) state_nxt = need_low ? PS_DRIVE_LOW : PS_SUPPLY_OFF;
            PS_DRIVE_LOW:  if (cnt_q == CNT_LAST) state_nxt = PS_SUPPLY_OFF;
            PS_SUPPLY_OFF: state_nxt = PS_OFF;
            default:       state_nxt = PS_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    // Drive-low dwell counter, restarted whenever the supply is on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state == PS_DRIVE_LOW) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    // Capture which lines to hold low at the moment power-down starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_low_q <= 1'b0;
            dat_low_q <= '0;
        end else if (state == PS_ON && !vdd1_ok) begin
            cmd_low_q <= card_ok;
            dat_low_q <= card_ok ? {DAT_W{1'b1}} : (oob_active ? oob_mask : '0);
        end
    end

    // Pad overrides and supply enable decoded from the state
    always_comb begin
        vdd1_en       = 1'b0;
        cmd_drive_low = 1'b0;
        cmd_hiz       = 1'b1;
        dat_drive_low = '0;
        dat_hiz       = {DAT_W{1'b1}};
        unique case (state)
            PS_ON: begin
                vdd1_en = 1'b1;
                cmd_hiz = 1'b0;
                dat_hiz = '0;
            end
            PS_DRIVE_LOW: begin
                vdd1_en       = 1'b1;
                cmd_drive_low = cmd_low_q;
                cmd_hiz       = ~cmd_low_q;
                dat_drive_low = dat_low_q;
                dat_hiz       = ~dat_low_q;
            end
            PS_SUPPLY_OFF: begin
                cmd_drive_low = cmd_low_q;
                cmd_hiz       = ~cmd_low_q;
                dat_drive_low = dat_low_q;
                dat_hiz       = ~dat_low_q;
            end
            default: begin
                vdd1_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sd_supply_ctrl.sv
// Module: top of the SD bus supply control register. Ties the card-present
// synchroniser, the register byte, the voltage qualifier and the
// power-down sequencer together. Assumes a single clock domain apart from
// card_present, which is asynchronous.
module sd_supply_ctrl
    import sdpwr_pkg::*;
#(
    parameter int DRIVE_LOW_CYCLES = 8,
    parameter int SYNC_STAGES      = 2,
    parameter int DAT_W            = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              card_present,
    input  logic              cap_vdd1_18,
    input  logic              cap_vdd1_30,
    input  logic              cap_vdd1_33,
    input  logic              cap_vdd2_18,
    input  logic              uhs2_mode,
    input  logic              dat2_oob_irq,
    output logic              vdd1_en,
    output logic [2:0]        vdd1_sel,
    output logic              vdd2_en,
    output logic [2:0]        vdd2_sel,
    output logic              sdclk_low,
    output logic              cmd_drive_low,
    output logic              cmd_hiz,
    output logic [DAT_W-1:0]  dat_drive_low,
    output logic [DAT_W-1:0]  dat_hiz
);

    supply_reg_t regs;
    pwr_state_e  seq_state;
    logic        card_ok;
    logic        vdd1_ok;
    logic        vdd2_ok;

    sdpwr_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b0)
    ) u_card_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (card_present),
        .q_sync  (card_ok)
    );

    sdpwr_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .hw_clr_vdd1 (~card_ok),
        .regs        (regs)
    );

    sdpwr_qualify u_qual (
        .regs        (regs),
        .cap_vdd1_18 (cap_vdd1_18),
        .cap_vdd1_30 (cap_vdd1_30),
        .cap_vdd1_33 (cap_vdd1_33),
        .cap_vdd2_18 (cap_vdd2_18),
        .vdd1_ok     (vdd1_ok),
        .vdd2_ok     (vdd2_ok)
    );

    sdpwr_seq #(
        .DRIVE_LOW_CYCLES (DRIVE_LOW_CYCLES),
        .DAT_W            (DAT_W),
        .OOB_LINE         (2)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .vdd1_ok       (vdd1_ok),
        .card_ok       (card_ok),
        .uhs2_mode     (uhs2_mode),
        .dat2_oob_irq  (dat2_oob_irq),
        .state         (seq_state),
        .vdd1_en       (vdd1_en),
        .cmd_drive_low (cmd_drive_low),
        .cmd_hiz       (cmd_hiz),
        .dat_drive_low (dat_drive_low),
        .dat_hiz       (dat_hiz)
    );

    // Register read-back and voltage-select outputs
    always_comb begin
        rd_data  = regs;
        vdd1_sel = regs.vdd1_code;
        vdd2_sel = regs.vdd2_code;
    end

    // Qualified VDD2 enable and SDCLK hold-low
    always_comb begin
        vdd2_en   = vdd2_ok;
        sdclk_low = ~regs.vdd1_on | ~vdd1_en;
    end

endmodule

// File: rtl/sdpwr_checker.sv
// Module: assertion checker for sd_supply_ctrl, attached by bind.
module sdpwr_checker
    import sdpwr_pkg::*;
#(
    parameter int DAT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       rd_data,
    input logic             card_ok,
    input logic             cap_vdd2_18,
    input pwr_state_e       seq_state,
    input logic             vdd1_en,
    input logic             vdd2_en,
    input logic             sdclk_low,
    input logic             cmd_drive_low,
    input logic             cmd_hiz,
    input logic [DAT_W-1:0] dat_drive_low,
    input logic [DAT_W-1:0] dat_hiz
);

    // R3: supply only turns on after the enable bit was set
    a_r3_rise_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vdd1_en) |-> $past(rd_data[0]));

    // R4: synchronised card absence clears the enable bit on the next edge
    a_r4_card_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !card_ok |=> !rd_data[0]);

    // R5: VDD2 enable only with a qualified request
    a_r5_vdd2_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        vdd2_en |-> (rd_data[4] && rd_data[7:5] == 3'b101 && cap_vdd2_18));

    // R6: clock held low whenever the enable bit is clear
    a_r6_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] |-> sdclk_low);

    // R7: a line held low at supply drop was already low before it
    a_r7_low_precedes_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vdd1_en) && cmd_drive_low) |-> $past(cmd_drive_low));

    // R7: no line is both driven low and tri-stated
    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_drive_low && cmd_hiz) && ((dat_drive_low & dat_hiz) == '0));

    // R10: fully off means supply off and every line tri-stated
    a_r10_off_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == PS_OFF) |-> (!vdd1_en && cmd_hiz && (&dat_hiz)));

endmodule

bind sd_supply_ctrl sdpwr_checker #(
    .DAT_W (DAT_W)
) u_sdpwr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_data       (rd_data),
    .card_ok       (card_ok),
    .cap_vdd2_18   (cap_vdd2_18),
    .seq_state     (seq_state),
    .vdd1_en       (vdd1_en),
    .vdd2_en       (vdd2_en),
    .sdclk_low     (sdclk_low),
    .cmd_drive_low (cmd_drive_low),
    .cmd_hiz       (cmd_hiz),
    .dat_drive_low (dat_drive_low),
    .dat_hiz       (dat_hiz)
);

// File: tb/test_sd_supply_ctrl.sv
// Scoreboard bench: driver pushes expectations, monitor compares at negedge.
module test_sd_supply_ctrl;

    localparam int DL = 8;

    // Observation selectors
    localparam int S_RD = 0, S_V1 = 1, S_V2 = 2, S_CLK = 3,
                   S_LOW = 4, S_HIZ = 5, S_SEL1 = 6, S_SEL2 = 7;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       card_present;
    logic       cap_vdd1_18, cap_vdd1_30, cap_vdd1_33, cap_vdd2_18;
    logic       uhs2_mode, dat2_oob_irq;
    logic       vdd1_en, vdd2_en, sdclk_low;
    logic [2:0] vdd1_sel, vdd2_sel;
    logic       cmd_drive_low, cmd_hiz;
    logic [3:0] dat_drive_low, dat_hiz;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      req;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    sd_supply_ctrl #(.DRIVE_LOW_CYCLES(DL)) i_sd_supply_ctrl (
        .clk, .rst_n, .wr_en, .wr_data, .rd_data, .card_present,
        .cap_vdd1_18, .cap_vdd1_30, .cap_vdd1_33, .cap_vdd2_18,
        .uhs2_mode, .dat2_oob_irq, .vdd1_en, .vdd1_sel, .vdd2_en,
        .vdd2_sel, .sdclk_low, .cmd_drive_low, .cmd_hiz,
        .dat_drive_low, .dat_hiz
    );

    function automatic logic [7:0] observe(int sel);
        case (sel)
            S_RD:    return rd_data;
            S_V1:    return {7'd0, vdd1_en};
            S_V2:    return {7'd0, vdd2_en};
            S_CLK:   return {7'd0, sdclk_low};
            S_LOW:   return {3'd0, cmd_drive_low, dat_drive_low};
            S_HIZ:   return {3'd0, cmd_hiz, dat_hiz};
            S_SEL1:  return {5'd0, vdd1_sel};
            default: return {5'd0, vdd2_sel};
        endcase
    endfunction

    task automatic expect_val(int sel, logic [7:0] e, string req);
        exp_item_t it;
        it.sel = sel;
        it.exp = e;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_reg(logic [7:0] d);
        tick();
        wr_en   = 1'b1;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
    endtask

    // Monitor: compare pending expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; card_present = 1'b1;
        cap_vdd1_18 = 1'b1; cap_vdd1_30 = 1'b1; cap_vdd1_33 = 1'b1;
        cap_vdd2_18 = 1'b1; uhs2_mode = 1'b0; dat2_oob_irq = 1'b0;
        repeat (3) tick();
        // R1 reset state
        expect_val(S_RD,  8'h00, "R1");
        expect_val(S_V1,  8'h00, "R1");
        expect_val(S_V2,  8'h00, "R1");
        expect_val(S_CLK, 8'h01, "R1");
        expect_val(S_LOW, 8'h00, "R1");
        expect_val(S_HIZ, 8'h1F, "R1");
        tick();
        rst_n = 1'b1;
        repeat (4) tick();

        // R2 / R3: 1.8V supported
        write_reg(8'h0B);
        expect_val(S_RD,   8'h0B, "R2");
        expect_val(S_V1,   8'h00, "R3");
        expect_val(S_CLK,  8'h01, "R6");
        expect_val(S_SEL1, 8'h05, "R11");
        tick();
        expect_val(S_V1,  8'h01, "R3");
        expect_val(S_CLK, 8'h00, "R6");
        expect_val(S_LOW, 8'h00, "R10");
        expect_val(S_HIZ, 8'h00, "R10");

        // R7: software power-off with card present
        write_reg(8'h0A);
        expect_val(S_CLK, 8'h01, "R6");
        expect_val(S_V1,  8'h01, "R7");
        tick();
        expect_val(S_LOW, 8'h1F, "R7");
        expect_val(S_HIZ, 8'h00, "R7");
        expect_val(S_V1,  8'h01, "R7");
        repeat (DL - 1) tick();
        expect_val(S_V1,  8'h01, "R7");
        expect_val(S_LOW, 8'h1F, "R7");
        tick();
        expect_val(S_V1,  8'h00, "R7");
        expect_val(S_LOW, 8'h1F, "R7");
        expect_val(S_HIZ, 8'h00, "R7");
        tick();
        expect_val(S_LOW, 8'h00, "R7");
        expect_val(S_HIZ, 8'h1F, "R10");

        // R3: unsupported and reserved codes
        cap_vdd1_30 = 1'b0;
        write_reg(8'h0D);
        tick(); tick();
        expect_val(S_V1,  8'h00, "R3");
        expect_val(S_CLK, 8'h01, "R6");
        write_reg(8'h09);
        tick();
        expect_val(S_V1, 8'h00, "R3");
        write_reg(8'h01);
        tick();
        expect_val(S_V1, 8'h00, "R3");
        cap_vdd1_30 = 1'b1;
        write_reg(8'h0D);
        tick();
        expect_val(S_V1, 8'h01, "R3");
        write_reg(8'h0C);
        repeat (DL + 3) tick();
        expect_val(S_V1, 8'h00, "R7");
        write_reg(8'h0F);
        tick();
        expect_val(S_V1,   8'h01, "R3");
        expect_val(S_SEL1, 8'h07, "R11");

        // R4 / R9: card removal without out-of-band use
        card_present = 1'b0;
        tick(); tick();
        expect_val(S_RD, 8'h0F, "R4");
        tick();
        expect_val(S_RD, 8'h0E, "R4");
        expect_val(S_V1, 8'h01, "R4");
        tick();
        expect_val(S_V1,  8'h00, "R9");
        expect_val(S_HIZ, 8'h1F, "R9");
        expect_val(S_LOW, 8'h00, "R9");
        tick();
        expect_val(S_HIZ, 8'h1F, "R9");

        // R4: hardware clear beats a write
        write_reg(8'h0F);
        expect_val(S_RD, 8'h0E, "R4");
        tick();
        expect_val(S_V1, 8'h00, "R4");

        // R8: UHS-II out-of-band DAT[2] on card removal
        card_present = 1'b1;
        repeat (3) tick();
        uhs2_mode = 1'b1; dat2_oob_irq = 1'b1;
        write_reg(8'h0F);
        tick();
        expect_val(S_V1, 8'h01, "R8");
        card_present = 1'b0;
        tick(); tick(); tick();
        expect_val(S_RD,  8'h0E, "R8");
        expect_val(S_LOW, 8'h00, "R8");
        tick();
        expect_val(S_LOW, 8'h04, "R8");
        expect_val(S_HIZ, 8'h1B, "R8");
        expect_val(S_V1,  8'h01, "R8");
        repeat (DL - 1) tick();
        expect_val(S_V1, 8'h01, "R8");
        tick();
        expect_val(S_V1,  8'h00, "R8");
        expect_val(S_LOW, 8'h04, "R8");
        tick();
        expect_val(S_HIZ, 8'h1F, "R8");
        expect_val(S_LOW, 8'h00, "R8");

        // R5: VDD2 qualification
        card_present = 1'b1; uhs2_mode = 1'b0; dat2_oob_irq = 1'b0;
        repeat (3) tick();
        write_reg(8'hB0);
        expect_val(S_V2,   8'h01, "R5");
        expect_val(S_SEL2, 8'h05, "R11");
        tick();
        cap_vdd2_18 = 1'b0;
        expect_val(S_V2, 8'h00, "R5");
        tick();
        cap_vdd2_18 = 1'b1;
        expect_val(S_V2, 8'h01, "R5");
        write_reg(8'h90);
        expect_val(S_V2, 8'h00, "R5");
        write_reg(8'hA0);
        expect_val(S_V2, 8'h00, "R5");
        expect_val(S_RD, 8'hA0, "R2");
        write_reg(8'hF0);
        expect_val(S_V2,   8'h00, "R5");
        expect_val(S_SEL2, 8'h07, "R11");

        tick(); tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule